// File: doc/BRIEF.md
# Receive Parity Checker with Automatic Attention

This block watches bytes arriving on a parallel peripheral bus in the receive direction. Each byte travels with one parity bit, and the block checks it for odd parity. When the inbound handshake strobe rises, the block captures the byte and answers with its own acknowledge strobe. An internal FIFO-to-FIFO transfer strobe lets the same parity rule be applied to bytes moving between the two internal FIFOs.

A bad byte sets a sticky status flag. That flag drives a level interrupt when the interrupt enable is set. When the block acts as initiator and attention-on-error is enabled, a bad bus byte also raises the attention output. The acknowledge for that byte is then held one extra cycle, so that attention is already driven before the acknowledge drops. The transfer is not aborted. Later bytes are captured and acknowledged normally, and attention stays up until the phase-change strobe or an explicit clear arrives.

Top module: `rxpar_guard`

## Requirements
- R1: A captured byte is bad when its eight data bits and its parity bit hold an even number of ones. The byte is captured on the clock edge that sees `hs_in_i` rise. A bad byte sets `err_sts_o` in the cycle after that edge.
- R2: While `chk_en_i` is 0, neither a bus byte nor a FIFO transfer can set `err_sts_o` or `atn_o`.
- R3: `err_sts_o` is sticky. It is cleared only by `sts_clr_i`. If a new error arrives in the same cycle as the clear, the flag stays set.
- R4: `irq_o` is 1 exactly when `err_sts_o` is 1 and `irq_en_i` is 1, with no added delay.
- R5: A pulse on `fifo_xfer_i` checks `fifo_data_i`/`fifo_par_i` with the rule of R1 and sets `err_sts_o` in the next cycle. It never raises `atn_o`.
- R6: `atn_o` is raised by a bad bus byte only when `role_i` is 1 (initiator), `atn_en_i` is 1 and `chk_en_i` is 1. When `role_i` is 0 (target), it is never raised.
- R7: `hs_out_o` rises in the cycle after `hs_in_i` rises. It normally falls one cycle after `hs_in_i` is seen low. For a byte that raised attention, the fall comes one cycle later than that.
- R8: After an error, later bytes are still captured and acknowledged with normal timing, and `atn_o` stays high.
- R9: A high `atn_o` is cleared by `phase_chg_i` or `atn_clr_i` in the next cycle. A bad byte that raises attention in the same cycle wins over the clear.
- R10: A low `rst_ni` clears `err_sts_o`, `atn_o`, `irq_o` and `hs_out_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| role_i | input | 1 | 1 = initiator, 0 = target |
| chk_en_i | input | 1 | Parity checking enable |
| atn_en_i | input | 1 | Attention-on-error enable |
| irq_en_i | input | 1 | Interrupt enable for the parity source |
| hs_in_i | input | 1 | Inbound handshake strobe, rising edge captures byte |
| bus_data_i | input | 8 | Received data byte |
| bus_par_i | input | 1 | Received parity bit |
| fifo_xfer_i | input | 1 | FIFO-to-FIFO transfer strobe |
| fifo_data_i | input | 8 | Byte moving between FIFOs |
| fifo_par_i | input | 1 | Parity of the moving byte |
| phase_chg_i | input | 1 | Bus phase change strobe |
| atn_clr_i | input | 1 | Explicit attention clear |
| sts_clr_i | input | 1 | Read-clear strobe for the status flag |
| hs_out_o | output | 1 | Outbound acknowledge strobe |
| atn_o | output | 1 | Attention output |
| err_sts_o | output | 1 | Sticky parity error status |
| irq_o | output | 1 | Parity error interrupt |

## Verification
The bench walks a table of bytes with even and odd ones counts under every mix of role and enables. It checks that the acknowledge release slips by exactly one cycle only when attention was raised. A design that held the release in target mode, or never held it, shows up as a wrong acknowledge level one cycle after the strobe falls. The bench also drives the clear strobes in the same cycle as a fresh error, which exposes a design that lets the clear win. It sends good bytes after a bad one, which catches a design that drops attention or stops acknowledging. Finally it sends FIFO transfers with attention enabled, which catches a design that routes FIFO errors onto the attention line.

// File: rtl/rxpar_pkg.sv
package rxpar_pkg;
  typedef enum logic {
    ROLE_TARGET = 1'b0,
    ROLE_INIT   = 1'b1
  } role_e;

  localparam int unsigned SRC_N    = 2;
  localparam int unsigned SRC_BUS  = 0;
  localparam int unsigned SRC_FIFO = 1;
endpackage

// File: rtl/rxpar_check.sv
module rxpar_check #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         par_i,
  input  logic         sample_i,
  input  logic         en_i,
  output logic         bad_o
);
  localparam int unsigned WORD_W = W + 1;

  logic [WORD_W-1:0] word;
  logic              odd_ones;

  always_comb begin
    word     = {par_i, data_i};
    odd_ones = ^word;
    bad_o    = sample_i & en_i & ~odd_ones;
  end
endmodule

// File: rtl/rxpar_handshake.sv
module rxpar_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_in_i,
  input  logic hold_set_i,
  output logic rise_o,
  output logic ack_o
);
  logic hs_q,   hs_d;
  logic ack_q,  ack_d;
  logic hold_q, hold_d;

  assign rise_o = hs_in_i & ~hs_q;

  always_comb begin
    hs_d   = hs_in_i;
    ack_d  = ack_q;
    hold_d = hold_q;
    if (rise_o) begin
      ack_d  = 1'b1;
      hold_d = hold_set_i;
    end else if (ack_q && !hs_in_i) begin
      if (hold_q) begin
        hold_d = 1'b0;
      end else begin
        ack_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q   <= 1'b0;
      ack_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hs_q   <= hs_d;
      ack_q  <= ack_d;
      hold_q <= hold_d;
    end
  end

  assign ack_o = ack_q;

  // The acknowledge only ever rises in answer to an inbound strobe.
  assert_ack_answers_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(hs_in_i));

  // A pending hold keeps the acknowledge up for the next cycle.
  assert_hold_keeps_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && ack_q) |=> ack_q);
endmodule

// File: rtl/rxpar_flags.sv
module rxpar_flags
  import rxpar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_bad_i,
  input  logic fifo_bad_i,
  input  logic role_i,
  input  logic atn_en_i,
  input  logic irq_en_i,
  input  logic phase_chg_i,
  input  logic atn_clr_i,
  input  logic sts_clr_i,
  output logic atn_set_o,
  output logic sts_o,
  output logic atn_o,
  output logic irq_o
);
  logic sts_q, sts_d;
  logic atn_q, atn_d;
  logic sts_en, atn_en;

  always_comb begin
    atn_set_o = bus_bad_i & (role_i == ROLE_INIT) & atn_en_i;

    sts_en = sts_clr_i | bus_bad_i | fifo_bad_i;
    sts_d  = (sts_q & ~sts_clr_i) | bus_bad_i | fifo_bad_i;

    atn_en = atn_set_o | phase_chg_i | atn_clr_i;
    atn_d  = atn_set_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      atn_q <= 1'b0;
    end else if (atn_en) begin
      atn_q <= atn_d;
    end
  end

  assign sts_o = sts_q;
  assign atn_o = atn_q;
  assign irq_o = sts_q & irq_en_i;

  assert_sticky_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !sts_clr_i) |=> sts_q);

  assert_target_no_atn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_i == ROLE_TARGET && !atn_q) |=> !atn_q);

  assert_atn_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (atn_q && !phase_chg_i && !atn_clr_i) |=> atn_q);
endmodule

// File: rtl/rxpar_guard.sv
module rxpar_guard
  import rxpar_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              role_i,
  input  logic              chk_en_i,
  input  logic              atn_en_i,
  input  logic              irq_en_i,
  input  logic              hs_in_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_par_i,
  input  logic              fifo_xfer_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_par_i,
  input  logic              phase_chg_i,
  input  logic              atn_clr_i,
  input  logic              sts_clr_i,
  output logic              hs_out_o,
  output logic              atn_o,
  output logic              err_sts_o,
  output logic              irq_o
);
  localparam int unsigned SYNC_N = 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[SYNC_N-1];

  logic                    bus_rise;
  logic                    atn_set;
  logic [SRC_N-1:0]        src_smp;
  logic [SRC_N-1:0]        src_par;
  logic [SRC_N-1:0]        src_bad;
  logic [DATA_W-1:0]       src_dat [SRC_N];

  always_comb begin
    src_smp[SRC_BUS]  = bus_rise;
    src_par[SRC_BUS]  = bus_par_i;
    src_dat[SRC_BUS]  = bus_data_i;
    src_smp[SRC_FIFO] = fifo_xfer_i;
    src_par[SRC_FIFO] = fifo_par_i;
    src_dat[SRC_FIFO] = fifo_data_i;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    rxpar_check #(.W(DATA_W)) i_check (
      .data_i   (src_dat[g]),
      .par_i    (src_par[g]),
      .sample_i (src_smp[g]),
      .en_i     (chk_en_i),
      .bad_o    (src_bad[g])
    );
  end

  rxpar_handshake i_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .hs_in_i    (hs_in_i),
    .hold_set_i (atn_set),
    .rise_o     (bus_rise),
    .ack_o      (hs_out_o)
  );

  rxpar_flags i_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .bus_bad_i   (src_bad[SRC_BUS]),
    .fifo_bad_i  (src_bad[SRC_FIFO]),
    .role_i      (role_i),
    .atn_en_i    (atn_en_i),
    .irq_en_i    (irq_en_i),
    .phase_chg_i (phase_chg_i),
    .atn_clr_i   (atn_clr_i),
    .sts_clr_i   (sts_clr_i),
    .atn_set_o   (atn_set),
    .sts_o       (err_sts_o),
    .atn_o       (atn_o),
    .irq_o       (irq_o)
  );

  // Attention comes up together with the acknowledge and is still up
  // one cycle later: attention leads the release.
  assert_atn_leads_release_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(atn_o) |=> hs_out_o);

  assert_status_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(err_sts_o) |-> $past(chk_en_i));

  assert_atn_gating_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(atn_o) |-> $past(role_i && atn_en_i && chk_en_i));

  assert_fifo_no_atn_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (fifo_xfer_i && !bus_rise && !atn_o) |=> !atn_o);
endmodule

// File: tb/test_rxpar_guard.sv
module test_rxpar_guard;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       role, chk_en, atn_en, irq_en;
  logic       hs_in;
  logic [7:0] bus_data;
  logic       bus_par;
  logic       fifo_xfer;
  logic [7:0] fifo_data;
  logic       fifo_par;
  logic       phase_chg, atn_clr, sts_clr;
  logic       hs_out, atn, sts, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rxpar_guard i_rxpar_guard (
    .clk_i(clk), .rst_ni(rst_n), .role_i(role), .chk_en_i(chk_en),
    .atn_en_i(atn_en), .irq_en_i(irq_en), .hs_in_i(hs_in),
    .bus_data_i(bus_data), .bus_par_i(bus_par), .fifo_xfer_i(fifo_xfer),
    .fifo_data_i(fifo_data), .fifo_par_i(fifo_par), .phase_chg_i(phase_chg),
    .atn_clr_i(atn_clr), .sts_clr_i(sts_clr), .hs_out_o(hs_out),
    .atn_o(atn), .err_sts_o(sts), .irq_o(irq)
  );

  // {role, chk_en, atn_en, irq_en, data[7:0], par, exp_sts, exp_atn, exp_irq}
  localparam logic [15:0] VEC [8] = '{
    16'b1111_00000000_1_000,
    16'b1111_00000000_0_111,
    16'b1110_00000011_0_110,
    16'b1101_11111111_0_101,
    16'b0111_10000001_0_101,
    16'b1011_00000001_1_000,
    16'b1111_01111111_0_000,
    16'b0111_10100101_1_000
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] d, input logic p);
    bus_data = d;
    bus_par  = p;
    hs_in    = 1'b1;
    tick();
  endtask

  task automatic drop_strobe(input logic held, input string req);
    hs_in = 1'b0;
    tick();
    check(req, "ack one cycle after strobe low", hs_out, held);
    if (held) begin
      tick();
      check(req, "ack after hold cycle", hs_out, 1'b0);
    end
  endtask

  task automatic clear_all();
    sts_clr = 1'b1;
    atn_clr = 1'b1;
    tick();
    sts_clr = 1'b0;
    atn_clr = 1'b0;
  endtask

  task automatic fifo_move(input logic [7:0] d, input logic p);
    fifo_data = d;
    fifo_par  = p;
    fifo_xfer = 1'b1;
    tick();
    fifo_xfer = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R10: actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; role = 1'b1; chk_en = 1'b1; atn_en = 1'b1; irq_en = 1'b1;
    hs_in = 1'b0; bus_data = '0; bus_par = 1'b0; fifo_xfer = 1'b0;
    fifo_data = '0; fifo_par = 1'b0; phase_chg = 1'b0; atn_clr = 1'b0;
    sts_clr = 1'b0;
    repeat (3) tick();
    // R10: reset state
    check("R10", "reset sts", sts, 1'b0);
    check("R10", "reset atn", atn, 1'b0);
    check("R10", "reset irq", irq, 1'b0);
    check("R10", "reset ack", hs_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();

    // Table walk: R1, R2, R4, R6, R7
    for (int i = 0; i < 8; i++) begin
      role   = VEC[i][15];
      chk_en = VEC[i][14];
      atn_en = VEC[i][13];
      irq_en = VEC[i][12];
      clear_all();
      put_byte(VEC[i][11:4], VEC[i][3]);
      check("R1", $sformatf("vec%0d sts", i), sts, VEC[i][2]);
      check("R6", $sformatf("vec%0d atn", i), atn, VEC[i][1]);
      check("R4", $sformatf("vec%0d irq", i), irq, VEC[i][0]);
      check("R7", $sformatf("vec%0d ack up", i), hs_out, 1'b1);
      drop_strobe(VEC[i][1], "R7");
    end

    // R3 sticky across a good byte, R8 transfer continues, R4 mask
    role = 1'b1; chk_en = 1'b1; atn_en = 1'b1; irq_en = 1'b1;
    clear_all();
    put_byte(8'h00, 1'b0);
    drop_strobe(1'b1, "R7");
    put_byte(8'h10, 1'b0);
    check("R8", "ack for byte after error", hs_out, 1'b1);
    check("R8", "atn kept after error", atn, 1'b1);
    check("R3", "sts sticky over good byte", sts, 1'b1);
    drop_strobe(1'b0, "R8");
    irq_en = 1'b0;
    #1;
    check("R4", "irq masked", irq, 1'b0);
    irq_en = 1'b1;
    #1;
    check("R4", "irq unmasked", irq, 1'b1);

    // R9 phase change clears attention, status untouched
    phase_chg = 1'b1;
    tick();
    phase_chg = 1'b0;
    check("R9", "atn after phase change", atn, 1'b0);
    check("R3", "sts after phase change", sts, 1'b1);

    // R9 clear in the same cycle as a new bad byte: set wins
    atn_clr = 1'b1;
    put_byte(8'h00, 1'b0);
    atn_clr = 1'b0;
    check("R9", "atn set beats clear", atn, 1'b1);
    drop_strobe(1'b1, "R7");
    atn_clr = 1'b1;
    tick();
    atn_clr = 1'b0;
    check("R9", "atn after explicit clear", atn, 1'b0);

    // R3 clear in the same cycle as a FIFO error: set wins; R5 no attention
    sts_clr = 1'b1;
    fifo_move(8'h03, 1'b0);
    sts_clr = 1'b0;
    check("R3", "sts set beats clear", sts, 1'b1);
    check("R5", "fifo error leaves atn low", atn, 1'b0);
    sts_clr = 1'b1;
    tick();
    sts_clr = 1'b0;
    check("R3", "sts after clear", sts, 1'b0);
    fifo_move(8'h07, 1'b0);
    check("R5", "fifo good byte", sts, 1'b0);
    fifo_move(8'h07, 1'b1);
    check("R5", "fifo bad byte", sts, 1'b1);
    clear_all();
    chk_en = 1'b0;
    fifo_move(8'h03, 1'b0);
    check("R2", "fifo unchecked when disabled", sts, 1'b0);
    chk_en = 1'b1;

    // R10 reset in mid-run clears flags and ack
    put_byte(8'h00, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R10", "async clear sts", sts, 1'b0);
    check("R10", "async clear atn", atn, 1'b0);
    check("R10", "async clear ack", hs_out, 1'b0);
    hs_in = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule